// File: doc/BRIEF.md
# Zero-High-Bits-From-Index Execution Unit

This unit is one slice of an integer ALU. It takes a source operand and an index operand. It keeps only the source bits that lie below a bit position, and it clears every bit at or above that position. The position comes from the low byte of the index operand. The result leaves through a register one cycle after a valid request, together with the carry, zero, sign and overflow flags and a write-enable mask for those four flags.

Two operand sizes are supported: a narrow 32-bit form and a wide 64-bit form. The wide form is granted only while the core runs in long mode. In every other mode a wide request is carried out as a narrow one. If the low byte of the index is not below the active width, nothing is cleared and the carry flag is set.

A request that has the vector-length control bit set is illegal. It raises an undefined-opcode strobe instead of a result, and the previous result and flags are held.

Top module: `zhb_unit`

## Requirements
- R1: The bit position n is taken only from index bits [7:0]. All higher index bits have no effect on the result or on the flags.
- R2: In the narrow form with n < 32, result bits n..31 are zero, bits below n equal the source, bits [63:32] are zero, and CF is 0.
- R3: In the wide form with n < 64, result bits n..63 are zero, bits below n equal the source, and CF is 0.
- R4: When n is greater than or equal to the active width (32 or 64), CF is 1 and the result equals the source at the active width. In the narrow form bits [63:32] are still zero.
- R5: ZF is 1 exactly when the 64-bit result is zero. SF is result bit 31 in the narrow form and result bit 63 in the wide form.
- R6: OF is 0 with every result.
- R7: A wide request (wide_req_i=1) made while long_mode_i=0 is executed as the narrow form.
- R8: A request with vlen_i=1 gives ud_o=1 one cycle later, with out_valid_o=0 and flag_we_o=0. result_o, cf_o, zf_o, sf_o and of_o keep their previous values.
- R9: A request with vlen_i=0 gives out_valid_o=1 exactly one cycle later. flag_we_o is 4'b1111 in that cycle and 4'b0000 whenever out_valid_o is 0. The bit order of flag_we_o is [0] CF, [1] ZF, [2] SF, [3] OF.
- R10: While rst_n is low, out_valid_o, ud_o, flag_we_o and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid_i | input | 1 | Request strobe |
| src_i | input | 64 | Source operand |
| idx_i | input | 64 | Index operand; only bits [7:0] are used |
| wide_req_i | input | 1 | Requests the 64-bit form |
| long_mode_i | input | 1 | Core is in long mode; the 64-bit form is granted only when this is 1 |
| vlen_i | input | 1 | Vector-length control bit; 1 makes the request illegal |
| out_valid_o | output | 1 | Result and flags are valid |
| result_o | output | 64 | Result |
| cf_o | output | 1 | Carry flag: index out of range |
| zf_o | output | 1 | Zero flag |
| sf_o | output | 1 | Sign flag |
| of_o | output | 1 | Overflow flag, always 0 |
| flag_we_o | output | 4 | Flag write enables {OF, SF, ZF, CF} |
| ud_o | output | 1 | Undefined-opcode exception strobe |

## Verification
The bench builds the unit with its default parameters: a 64-bit datapath, a 32-bit narrow form and an 8-bit index field. With these values the index byte can reach every boundary that matters: positions 0, 31, 32, 63 and 64, up to 255. Index operands with bits set above the byte show that those bits are ignored. Both operand sizes are exercised, and so is the fallback to the narrow form outside long mode. The table ends with a held-state check around an illegal vector-length request.

// File: rtl/zhb_pkg.sv
package zhb_pkg;
  localparam int unsigned DATA_W   = 64;
  localparam int unsigned NARROW_W = 32;
  localparam int unsigned IDX_W    = 8;
  localparam int unsigned NFLAGS   = 4;

  // positions in the flag write-enable mask
  localparam int unsigned FL_CF = 0;
  localparam int unsigned FL_ZF = 1;
  localparam int unsigned FL_SF = 2;
  localparam int unsigned FL_OF = 3;

  typedef struct packed {
    logic of_f;
    logic sf_f;
    logic zf_f;
    logic cf_f;
  } zhb_flags_t;
endpackage

// File: rtl/zhb_mask.sv
module zhb_mask #(
  parameter int unsigned DATA_W   = zhb_pkg::DATA_W,
  parameter int unsigned NARROW_W = zhb_pkg::NARROW_W,
  parameter int unsigned IDX_W    = zhb_pkg::IDX_W
) (
  input  logic [DATA_W-1:0] src_i,
  input  logic [IDX_W-1:0]  pos_i,
  input  logic              wide_i,
  output logic [DATA_W-1:0] res_o,
  output logic              oor_o
);
  localparam int unsigned WID_W = $clog2(DATA_W + 1);
  localparam int unsigned CMP_W = ((IDX_W > WID_W) ? IDX_W : WID_W) + 1;

  logic [CMP_W-1:0]  width_c;
  logic [CMP_W-1:0]  pos_c;
  logic [CMP_W-1:0]  limit_c;
  logic [DATA_W-1:0] keep_c;

  always_comb begin
    width_c = wide_i ? CMP_W'(DATA_W) : CMP_W'(NARROW_W);
    pos_c   = CMP_W'(pos_i);
    oor_o   = (pos_c >= width_c);
    // keep bits below min(position, active width)
    limit_c = oor_o ? width_c : pos_c;
  end

  for (genvar b = 0; b < DATA_W; b++) begin : g_keep
    assign keep_c[b] = (CMP_W'(b) < limit_c);
  end

  assign res_o = src_i & keep_c;
endmodule

// File: rtl/zhb_flags.sv
module zhb_flags #(
  parameter int unsigned DATA_W   = zhb_pkg::DATA_W,
  parameter int unsigned NARROW_W = zhb_pkg::NARROW_W
) (
  input  logic [DATA_W-1:0]        res_i,
  input  logic                     wide_i,
  input  logic                     oor_i,
  output zhb_pkg::zhb_flags_t      flags_o
);
  always_comb begin
    flags_o.cf_f = oor_i;
    flags_o.zf_f = (res_i == '0);
    flags_o.sf_f = wide_i ? res_i[DATA_W-1] : res_i[NARROW_W-1];
    flags_o.of_f = 1'b0;
  end
endmodule

// File: rtl/zhb_unit.sv
module zhb_unit #(
  parameter int unsigned DATA_W   = zhb_pkg::DATA_W,
  parameter int unsigned NARROW_W = zhb_pkg::NARROW_W,
  parameter int unsigned IDX_W    = zhb_pkg::IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] idx_i,
  input  logic              wide_req_i,
  input  logic              long_mode_i,
  input  logic              vlen_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              cf_o,
  output logic              zf_o,
  output logic              sf_o,
  output logic              of_o,
  output logic [zhb_pkg::NFLAGS-1:0] flag_we_o,
  output logic              ud_o
);
  import zhb_pkg::*;

  logic              eff_wide_c;
  logic              load_c;
  logic              ud_c;
  logic [DATA_W-1:0] res_c;
  logic              oor_c;
  zhb_flags_t        flags_c;

  logic              valid_q, valid_d;
  logic              ud_q, ud_d;
  logic [DATA_W-1:0] res_q, res_d;
  zhb_flags_t        flags_q, flags_d;

  assign eff_wide_c = wide_req_i & long_mode_i;
  assign load_c     = in_valid_i & ~vlen_i;
  assign ud_c       = in_valid_i & vlen_i;

  zhb_mask #(
    .DATA_W(DATA_W), .NARROW_W(NARROW_W), .IDX_W(IDX_W)
  ) u_mask (
    .src_i (src_i),
    .pos_i (idx_i[IDX_W-1:0]),
    .wide_i(eff_wide_c),
    .res_o (res_c),
    .oor_o (oor_c)
  );

  zhb_flags #(
    .DATA_W(DATA_W), .NARROW_W(NARROW_W)
  ) u_flags (
    .res_i  (res_c),
    .wide_i (eff_wide_c),
    .oor_i  (oor_c),
    .flags_o(flags_c)
  );

  // next state
  always_comb begin
    valid_d = load_c;
    ud_d    = ud_c;
    res_d   = load_c ? res_c   : res_q;
    flags_d = load_c ? flags_c : flags_q;
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      ud_q    <= 1'b0;
      flags_q <= '0;
    end else begin
      valid_q <= valid_d;
      ud_q    <= ud_d;
      flags_q <= flags_d;
    end
  end

  // datapath register, enabled only on a legal request
  always_ff @(posedge clk) begin
    if (load_c) begin
      res_q <= res_d;
    end
  end

  assign out_valid_o = valid_q;
  assign ud_o        = ud_q;
  assign result_o    = res_q;
  assign cf_o        = flags_q.cf_f;
  assign zf_o        = flags_q.zf_f;
  assign sf_o        = flags_q.sf_f;
  assign of_o        = flags_q.of_f;
  assign flag_we_o   = {NFLAGS{valid_q}};
endmodule

// File: rtl/zhb_unit_chk.sv
module zhb_unit_chk #(
  parameter int unsigned DATA_W   = zhb_pkg::DATA_W,
  parameter int unsigned NARROW_W = zhb_pkg::NARROW_W,
  parameter int unsigned IDX_W    = zhb_pkg::IDX_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid_i,
  input logic [DATA_W-1:0] src_i,
  input logic [DATA_W-1:0] idx_i,
  input logic              wide_req_i,
  input logic              long_mode_i,
  input logic              vlen_i,
  input logic              out_valid_o,
  input logic [DATA_W-1:0] result_o,
  input logic              cf_o,
  input logic              zf_o,
  input logic              sf_o,
  input logic              of_o,
  input logic [zhb_pkg::NFLAGS-1:0] flag_we_o,
  input logic              ud_o
);
  // R6
  p_of_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> !of_o);

  // R5
  p_zf_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> (zf_o == (result_o == '0)));

  // R2, R7
  p_narrow_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && !$past(wide_req_i && long_mode_i)
      |-> (result_o[DATA_W-1:NARROW_W] == '0));

  // R4
  p_cf_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> (cf_o == (int'($past(idx_i[IDX_W-1:0])) >=
      (($past(wide_req_i && long_mode_i)) ? int'(DATA_W) : int'(NARROW_W)))));

  // R8
  p_ud_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ud_o |-> (!out_valid_o && flag_we_o == '0));

  p_ud_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ud_o |-> ($stable(cf_o) && $stable(zf_o) && $stable(sf_o)));

  // R9
  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid_i && !vlen_i |=> out_valid_o);

  p_we_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid_o |-> (flag_we_o == '0));
endmodule

bind zhb_unit zhb_unit_chk #(
  .DATA_W(DATA_W), .NARROW_W(NARROW_W), .IDX_W(IDX_W)
) u_chk (.*);

// File: tb/sim_zhb_unit.sv
module sim_zhb_unit;
  localparam int unsigned DW = 64;

  typedef struct packed {
    logic [DW-1:0] src;
    logic [DW-1:0] idx;
    logic          wide;
    logic          lm;
    logic [DW-1:0] exp_res;
    logic          exp_cf;
    logic          exp_zf;
    logic          exp_sf;
    logic [7:0]    req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    // R3 wide, n=8
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'd8,  1'b1, 1'b1, 64'h0000_0000_0000_00FF, 1'b0, 1'b0, 1'b0, 8'd3},
    // R3 wide, n=63
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'd63, 1'b1, 1'b1, 64'h7FFF_FFFF_FFFF_FFFF, 1'b0, 1'b0, 1'b0, 8'd3},
    // R5 wide, n=0 gives zero
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'd0,  1'b1, 1'b1, 64'h0,                   1'b0, 1'b1, 1'b0, 8'd5},
    // R4 wide, n=64
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'd64, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 1'b1, 8'd4},
    // R2 narrow, n=16
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'd16, 1'b0, 1'b1, 64'h0000_0000_0000_FFFF, 1'b0, 1'b0, 1'b0, 8'd2},
    // R4 narrow, n=32
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'd32, 1'b0, 1'b1, 64'h0000_0000_FFFF_FFFF, 1'b1, 1'b0, 1'b1, 8'd4},
    // R2 narrow, n=31
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'd31, 1'b0, 1'b1, 64'h0000_0000_7FFF_FFFF, 1'b0, 1'b0, 1'b0, 8'd2},
    // R1 high index bits ignored, n=4
    '{64'h1234_5678_9ABC_DEF5, 64'hFFFF_FFFF_FFFF_FF04, 1'b1, 1'b1, 64'h5, 1'b0, 1'b0, 1'b0, 8'd1},
    // R1 index 0x100 means n=0
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0100, 1'b1, 1'b1, 64'h0, 1'b0, 1'b1, 1'b0, 8'd1},
    // R7 wide request outside long mode, n=40 is out of narrow range
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'd40, 1'b1, 1'b0, 64'h0000_0000_FFFF_FFFF, 1'b1, 1'b0, 1'b1, 8'd7},
    // R4 wide, n=255
    '{64'h8000_0000_0000_0000, 64'd255, 1'b1, 1'b1, 64'h8000_0000_0000_0000, 1'b1, 1'b0, 1'b1, 8'd4},
    // R5 wide, bit 47 kept, sign from bit 63
    '{64'h0000_8000_0000_0000, 64'd48, 1'b1, 1'b1, 64'h0000_8000_0000_0000, 1'b0, 1'b0, 1'b0, 8'd5},
    // R2 narrow upper half dropped, result zero
    '{64'hFFFF_FFFF_0000_0000, 64'd20, 1'b0, 1'b1, 64'h0, 1'b0, 1'b1, 1'b0, 8'd2}
  };

  logic          clk;
  logic          rst_n;
  logic          in_valid_i;
  logic [DW-1:0] src_i;
  logic [DW-1:0] idx_i;
  logic          wide_req_i;
  logic          long_mode_i;
  logic          vlen_i;
  logic          out_valid_o;
  logic [DW-1:0] result_o;
  logic          cf_o, zf_o, sf_o, of_o;
  logic [3:0]    flag_we_o;
  logic          ud_o;

  int checks;
  int errors;
  bit done;

  zhb_unit u0 (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [DW-1:0] s, input logic [DW-1:0] x,
                       input logic w, input logic lm, input logic vl);
    @(negedge clk);
    in_valid_i  = 1'b1;
    src_i       = s;
    idx_i       = x;
    wide_req_i  = w;
    long_mode_i = lm;
    vlen_i      = vl;
    @(negedge clk);
    in_valid_i  = 1'b0;
    vlen_i      = 1'b0;
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; in_valid_i = 1'b0; src_i = '0; idx_i = '0;
    wide_req_i = 1'b0; long_mode_i = 1'b0; vlen_i = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 out_valid", DW'(out_valid_o), 0);
    chk("R10 ud", DW'(ud_o), 0);
    chk("R10 flags", DW'({of_o, sf_o, zf_o, cf_o}), 0);
    chk("R10 flag_we", DW'(flag_we_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      string t;
      issue(TBL[i].src, TBL[i].idx, TBL[i].wide, TBL[i].lm, 1'b0);
      t = $sformatf("R%0d row%0d", TBL[i].req, i);
      chk({t, " result"}, result_o, TBL[i].exp_res);
      chk({t, " cf"}, DW'(cf_o), DW'(TBL[i].exp_cf));
      chk({t, " zf"}, DW'(zf_o), DW'(TBL[i].exp_zf));
      chk({t, " sf"}, DW'(sf_o), DW'(TBL[i].exp_sf));
      chk($sformatf("R6 row%0d of", i), DW'(of_o), 0);
      chk($sformatf("R9 row%0d valid", i), DW'(out_valid_o), 1);
      chk($sformatf("R9 row%0d we", i), DW'(flag_we_o), 64'hF);
      chk($sformatf("R8 row%0d ud", i), DW'(ud_o), 0);
    end

    // R9 valid drops the cycle after an idle input
    @(negedge clk);
    chk("R9 idle valid", DW'(out_valid_o), 0);
    chk("R9 idle we", DW'(flag_we_o), 0);

    // R8 illegal vector length holds previous state
    issue(64'hFFFF_FFFF_FFFF_FFFF, 64'd64, 1'b1, 1'b1, 1'b0);
    issue(64'h0, 64'd0, 1'b1, 1'b1, 1'b1);
    chk("R8 ud", DW'(ud_o), 1);
    chk("R8 valid", DW'(out_valid_o), 0);
    chk("R8 we", DW'(flag_we_o), 0);
    chk("R8 result held", result_o, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R8 flags held", DW'({of_o, sf_o, zf_o, cf_o}), 64'h5);
    @(negedge clk);
    chk("R8 ud one cycle", DW'(ud_o), 0);

    // R10 asynchronous reset clears flags
    rst_n = 1'b0;
    #1;
    chk("R10 flags after reset", DW'({of_o, sf_o, zf_o, cf_o}), 0);
    chk("R10 valid after reset", DW'(out_valid_o), 0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule